// File: doc/BRIEF.md
# Read Capture Window Center Finder

This block watches a read-capture sweep, lane by lane, and turns it into a trained setting for each byte lane. An external sweep source presents one step per cycle as a phase/delay pair. With each step it supplies a match flag and an overrun flag for every lane. Each lane tracker moves through three states: searching, inside its passing window, and closed. It stores the setting where its window opened and the setting where the window closed.

When every lane taking part in the pass has closed its window, a sequencer visits the active lanes one at a time. For each lane it turns both window edges into a single linear position and takes the integer midpoint. A shared divider then splits the midpoint back into a phase and a delay. The smallest center phase across the active lanes is reported so the caller can choose a ready delay.

A pass covers either all data lanes or only the check-bit lane, which is the lane with index LANES. In full-rate operation only phases 0, 1, 4 and 5 are swept, so phases 4 and 5 are folded down by two before the midpoint is taken and unfolded afterwards.

Top module: `rdwin_center`

## Requirements
- R1: A searching lane enters its window after LOCK_CNT (default 3) consecutive matches without overrun at one phase/delay setting. A mismatch, or a step at a setting that differs from the previous step, restarts the count. The setting of the locking step is stored as the window start.
- R2: A lane inside its window stays there while it matches. On the first mismatch, or on a step flagged as the last of the sweep, it stores that step's setting as the window end and closes.
- R3: When an active lane reports overrun, that lane ignores the step and `step_hold` is high in the same cycle. An overrun on an inactive lane neither raises `step_hold` nor changes that lane's progress.
- R4: `all_done` is high exactly when the number of closed active lanes equals the number of active lanes. The active lanes are lanes 0..LANES-1, or only lane LANES when `ecc_pass` was high at the last `start`.
- R5: The linear position is phase*MAX_DLY + delay. The center is start + floor((end - start)/2). The center phase is center / MAX_DLY and the center delay is center mod MAX_DLY.
- R6: In full-rate mode, stored phases above 1 are reduced by 2 before linearizing, and a center phase above 1 is increased by 2 afterwards.
- R7: `min_phase` is the smallest center phase over the active lanes, starting from 10.
- R8: A lane whose end position lies below its start position has its `res_err` bit set and reports its start setting as its center.
- R9: After `all_done` rises, `busy` goes high. When all active lanes are computed, `busy` falls and `res_valid` rises. The results then hold still until `start`, which clears `res_valid` and reopens every lane.
- R10: After reset, `all_done`, `busy`, `res_valid` and `step_hold` are low, and every lane is searching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new pass and latch the mode inputs |
| ecc_pass | input | 1 | Pass covers only the check-bit lane |
| full_rate | input | 1 | Full-rate phase folding for this pass |
| step_valid | input | 1 | A sweep step is presented |
| step_phase | input | PH_W | Phase of the step |
| step_dly | input | $clog2(MAX_DLY) | Delay of the step |
| step_last | input | 1 | Step is the final setting of the sweep |
| lane_match | input | LANES+1 | Per-lane compare match |
| lane_ovr | input | LANES+1 | Per-lane overrun |
| step_hold | output | 1 | Sweep must repeat this step |
| all_done | output | 1 | Every active lane has closed |
| busy | output | 1 | Centers are being computed |
| res_valid | output | 1 | Center results are ready |
| res_phase | output | (LANES+1)*PH_W | Center phase per lane |
| res_dly | output | (LANES+1)*$clog2(MAX_DLY) | Center delay per lane |
| res_err | output | LANES+1 | End-before-start flag per lane |
| min_phase | output | max(PH_W,4) | Smallest active center phase |

## Verification
A lane tracker in the wrong state shows on `all_done` in the cycle after the step that should have closed the lane. A miscounted lock shifts the stored window start. That error only appears after the calculation, as a center phase or delay that is off by one or more. For this reason the bench checks `all_done` and `step_hold` on every cycle and checks each active lane's centers, error flag and minimum phase once `res_valid` rises. A fault in the fold or unfold of full-rate phases shows only in the full-rate pass, as a center that is shifted by a whole phase.

// File: rtl/rdwin_pkg.sv
`timescale 1ns/1ps
package rdwin_pkg;
   typedef enum logic [1:0] {
      LN_SEEK = 2'd0,
      LN_OPEN = 2'd1,
      LN_SHUT = 2'd2
   } lane_st_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_LOAD = 2'd1,
      SQ_DIV  = 2'd2
   } seq_st_e;
endpackage

// File: rtl/rdwin_lane.sv
`timescale 1ns/1ps
module rdwin_lane #(
   parameter int PH_W     = 3,
   parameter int DL_W     = 5,
   parameter int LOCK_CNT = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            active,
   input  logic            step,
   input  logic            ovr,
   input  logic            hit,
   input  logic            same,
   input  logic            last,
   input  logic [PH_W-1:0] ph,
   input  logic [DL_W-1:0] dl,
   output logic            shut,
   output logic [PH_W-1:0] s_ph,
   output logic [DL_W-1:0] s_dl,
   output logic [PH_W-1:0] e_ph,
   output logic [DL_W-1:0] e_dl
);
   import rdwin_pkg::*;
   localparam int CNT_W = $clog2(LOCK_CNT + 1);

   lane_st_e         st;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_n;
   logic             upd;

   assign upd   = step && active && !ovr;
   assign cnt_n = (same ? cnt : '0) + CNT_W'(1);
   assign shut  = (st == LN_SHUT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= LN_SEEK;
         cnt  <= '0;
         s_ph <= '0;
         s_dl <= '0;
         e_ph <= '0;
         e_dl <= '0;
      end else if (clear) begin
         st  <= LN_SEEK;
         cnt <= '0;
      end else if (upd) begin
         case (st)
            LN_SEEK: begin
               if (!hit) begin
                  cnt <= '0;
               end else if (cnt_n == CNT_W'(LOCK_CNT)) begin
                  st   <= LN_OPEN;
                  cnt  <= '0;
                  s_ph <= ph;
                  s_dl <= dl;
               end else begin
                  cnt <= cnt_n;
               end
            end
            LN_OPEN: begin
               if (!hit || last) begin
                  st   <= LN_SHUT;
                  e_ph <= ph;
                  e_dl <= dl;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rdwin_div.sv
`timescale 1ns/1ps
module rdwin_div #(
   parameter int N_W     = 8,
   parameter int DIVISOR = 20
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       go,
   input  logic [N_W-1:0]             num,
   output logic [N_W-1:0]             quo,
   output logic [$clog2(DIVISOR)-1:0] rem,
   output logic                       done
);
   localparam int DW  = $clog2(DIVISOR);
   localparam int R_W = DW + 1;
   localparam int C_W = $clog2(N_W + 1);

   logic [N_W-1:0] q;
   logic [R_W-1:0] r;
   logic [R_W-1:0] trial;
   logic           ge;
   logic [C_W-1:0] cnt;
   logic           run;

   assign trial = {r[R_W-2:0], q[N_W-1]};
   assign ge    = (trial >= R_W'(DIVISOR));
   assign quo   = q;
   assign rem   = r[DW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q    <= '0;
         r    <= '0;
         cnt  <= '0;
         run  <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            q   <= num;
            r   <= '0;
            cnt <= C_W'(N_W);
            run <= 1'b1;
         end else if (run) begin
            q   <= {q[N_W-2:0], ge};
            r   <= ge ? (trial - R_W'(DIVISOR)) : trial;
            cnt <= cnt - C_W'(1);
            if (cnt == C_W'(1)) begin
               run  <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/rdwin_center.sv
`timescale 1ns/1ps
module rdwin_center #(
   parameter int LANES    = 8,
   parameter int PH_W     = 3,
   parameter int MAX_DLY  = 20,
   parameter int LOCK_CNT = 3
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   start,
   input  logic                                   ecc_pass,
   input  logic                                   full_rate,
   input  logic                                   step_valid,
   input  logic [PH_W-1:0]                        step_phase,
   input  logic [$clog2(MAX_DLY)-1:0]             step_dly,
   input  logic                                   step_last,
   input  logic [LANES:0]                         lane_match,
   input  logic [LANES:0]                         lane_ovr,
   output logic                                   step_hold,
   output logic                                   all_done,
   output logic                                   busy,
   output logic                                   res_valid,
   output logic [(LANES+1)*PH_W-1:0]              res_phase,
   output logic [(LANES+1)*$clog2(MAX_DLY)-1:0]   res_dly,
   output logic [LANES:0]                         res_err,
   output logic [((PH_W < 4) ? 4 : PH_W)-1:0]     min_phase
);
   import rdwin_pkg::*;

   localparam int NL     = LANES + 1;
   localparam int DL_W   = $clog2(MAX_DLY);
   localparam int POS_W  = PH_W + DL_W;
   localparam int MP_W   = (PH_W < 4) ? 4 : PH_W;
   localparam int IX_W   = $clog2(NL);
   localparam int CW     = $clog2(NL + 1);
   localparam bit POW2   = ((MAX_DLY & (MAX_DLY - 1)) == 0);
   localparam int MIN_INIT = 10;

   if (MAX_DLY < 2) begin : g_chk_dly
      $error("MAX_DLY must be at least 2");
   end
   if (PH_W < 3) begin : g_chk_ph
      $error("PH_W must hold phase 5");
   end
   if (LOCK_CNT < 1) begin : g_chk_lock
      $error("LOCK_CNT must be at least 1");
   end
   if (LANES < 1) begin : g_chk_lanes
      $error("LANES must be at least 1");
   end

   // Pass mode and previous step position
   logic            mode_ecc, mode_fr;
   logic [PH_W-1:0] prev_ph;
   logic [DL_W-1:0] prev_dl;
   logic            prev_ok;
   logic            same;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_ecc <= 1'b0;
         mode_fr  <= 1'b0;
         prev_ph  <= '0;
         prev_dl  <= '0;
         prev_ok  <= 1'b0;
      end else if (start) begin
         mode_ecc <= ecc_pass;
         mode_fr  <= full_rate;
         prev_ok  <= 1'b0;
      end else if (step_valid) begin
         prev_ph <= step_phase;
         prev_dl <= step_dly;
         prev_ok <= 1'b1;
      end
   end

   assign same = prev_ok && (step_phase == prev_ph) && (step_dly == prev_dl);

   // Lane trackers
   logic [NL-1:0]   act, shut;
   logic [PH_W-1:0] s_ph_a [NL];
   logic [DL_W-1:0] s_dl_a [NL];
   logic [PH_W-1:0] e_ph_a [NL];
   logic [DL_W-1:0] e_dl_a [NL];

   for (genvar k = 0; k < NL; k++) begin : g_lane
      if (k == LANES) begin : g_chkbit
         assign act[k] = mode_ecc;
      end else begin : g_data
         assign act[k] = !mode_ecc;
      end
      rdwin_lane #(.PH_W(PH_W), .DL_W(DL_W), .LOCK_CNT(LOCK_CNT)) u_lane (
         .clk(clk), .rst_n(rst_n), .clear(start), .active(act[k]),
         .step(step_valid), .ovr(lane_ovr[k]), .hit(lane_match[k]),
         .same(same), .last(step_last), .ph(step_phase), .dl(step_dly),
         .shut(shut[k]), .s_ph(s_ph_a[k]), .s_dl(s_dl_a[k]),
         .e_ph(e_ph_a[k]), .e_dl(e_dl_a[k])
      );
   end

   logic [CW-1:0] shut_cnt;
   always_comb begin
      shut_cnt = '0;
      for (int k = 0; k < NL; k++) shut_cnt = shut_cnt + CW'(shut[k] & act[k]);
   end

   assign all_done  = (shut_cnt == (mode_ecc ? CW'(1) : CW'(LANES)));
   assign step_hold = step_valid && |(lane_ovr & act);

   // Linear positions and midpoint of the selected lane
   function automatic logic [POS_W-1:0] to_lin(input logic [PH_W-1:0] ph,
                                               input logic [DL_W-1:0] dl,
                                               input logic fr);
      logic [PH_W-1:0] pf;
      pf = (fr && ph > PH_W'(1)) ? ph - PH_W'(2) : ph;
      return POS_W'(pf) * POS_W'(MAX_DLY) + POS_W'(dl);
   endfunction

   seq_st_e         sq;
   logic [IX_W-1:0] idx;
   logic [IX_W-1:0] idx_first, idx_last;
   logic [POS_W-1:0] pos_s, pos_e, mid;
   logic            bad;

   assign idx_first = mode_ecc ? IX_W'(LANES) : '0;
   assign idx_last  = mode_ecc ? IX_W'(LANES) : IX_W'(LANES - 1);
   assign pos_s     = to_lin(s_ph_a[idx], s_dl_a[idx], mode_fr);
   assign pos_e     = to_lin(e_ph_a[idx], e_dl_a[idx], mode_fr);
   assign bad       = (pos_e < pos_s);
   assign mid       = bad ? pos_s : pos_s + ((pos_e - pos_s) >> 1);

   // Split of the midpoint into phase and delay
   logic             go;
   logic [POS_W-1:0] div_q;
   logic [DL_W-1:0]  div_r;
   logic             div_done;

   assign go = (sq == SQ_LOAD);

   if (POW2) begin : g_split_shift
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            div_q    <= '0;
            div_r    <= '0;
            div_done <= 1'b0;
         end else begin
            div_done <= go;
            if (go) begin
               div_q <= mid >> DL_W;
               div_r <= mid[DL_W-1:0];
            end
         end
      end
   end else begin : g_split_seq
      rdwin_div #(.N_W(POS_W), .DIVISOR(MAX_DLY)) u_div (
         .clk(clk), .rst_n(rst_n), .go(go), .num(mid),
         .quo(div_q), .rem(div_r), .done(div_done)
      );
   end

   logic [POS_W-1:0] q_adj;
   logic [PH_W-1:0]  q_ph;
   assign q_adj = (mode_fr && div_q > POS_W'(1)) ? div_q + POS_W'(2) : div_q;
   assign q_ph  = q_adj[PH_W-1:0];

   // Sequencer and result storage
   logic [PH_W-1:0] ph_q [NL];
   logic [DL_W-1:0] dl_q [NL];
   logic [NL-1:0]   err_q;
   logic [MP_W-1:0] minp;
   logic            res_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq    <= SQ_IDLE;
         idx   <= '0;
         res_v <= 1'b0;
         minp  <= MP_W'(MIN_INIT);
         err_q <= '0;
         for (int k = 0; k < NL; k++) begin
            ph_q[k] <= '0;
            dl_q[k] <= '0;
         end
      end else if (start) begin
         sq    <= SQ_IDLE;
         res_v <= 1'b0;
      end else begin
         case (sq)
            SQ_IDLE: if (all_done && !res_v) begin
               sq   <= SQ_LOAD;
               idx  <= idx_first;
               minp <= MP_W'(MIN_INIT);
            end
            SQ_LOAD: begin
               err_q[idx] <= bad;
               sq         <= SQ_DIV;
            end
            SQ_DIV: if (div_done) begin
               ph_q[idx] <= q_ph;
               dl_q[idx] <= div_r;
               if (MP_W'(q_ph) < minp) minp <= MP_W'(q_ph);
               if (idx == idx_last) begin
                  sq    <= SQ_IDLE;
                  res_v <= 1'b1;
               end else begin
                  idx <= idx + IX_W'(1);
                  sq  <= SQ_LOAD;
               end
            end
            default: sq <= SQ_IDLE;
         endcase
      end
   end

   for (genvar k = 0; k < NL; k++) begin : g_out
      assign res_phase[k*PH_W +: PH_W] = ph_q[k];
      assign res_dly[k*DL_W +: DL_W]   = dl_q[k];
   end

   assign res_err   = err_q;
   assign busy      = (sq != SQ_IDLE);
   assign res_valid = res_v;
   assign min_phase = minp;
endmodule

// File: rtl/rdwin_center_chk.sv
`timescale 1ns/1ps
module rdwin_center_chk #(
   parameter int MP_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            step_valid,
   input logic            step_hold,
   input logic            all_done,
   input logic            busy,
   input logic            res_valid,
   input logic [MP_W-1:0] min_phase
);
   // R3: a hold request only accompanies a presented step
   p_hold_with_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      step_hold |-> step_valid);

   // R4: calculation only begins once every active lane is closed
   p_busy_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> all_done);

   // R9: results appear only at the end of a calculation
   p_valid_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(res_valid) |-> $past(busy));

   // R9: ready results and an ongoing calculation exclude each other
   p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !busy);

   // R7: the minimum is frozen while results are presented
   p_min_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !start) |=> $stable(min_phase));

   // R7: a computed minimum lies below its initial value
   p_min_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (min_phase < MP_W'(10)));
endmodule

bind rdwin_center rdwin_center_chk #(.MP_W(MP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .step_valid(step_valid),
   .step_hold(step_hold), .all_done(all_done), .busy(busy),
   .res_valid(res_valid), .min_phase(min_phase)
);

// File: tb/rdwin_center_bench.sv
`timescale 1ns/1ps
module rdwin_center_bench;
   localparam int LANES = 4;
   localparam int NL    = LANES + 1;
   localparam int PH_W  = 3;
   localparam int MD    = 20;
   localparam int DL_W  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, ecc_pass = 1'b0, full_rate = 1'b0;
   logic step_valid = 1'b0, step_last = 1'b0;
   logic [PH_W-1:0] step_phase = '0;
   logic [DL_W-1:0] step_dly = '0;
   logic [NL-1:0] lane_match = '0, lane_ovr = '0;
   logic step_hold, all_done, busy, res_valid;
   logic [NL*PH_W-1:0] res_phase;
   logic [NL*DL_W-1:0] res_dly;
   logic [NL-1:0] res_err;
   logic [3:0] min_phase;

   always #4 clk = ~clk;

   rdwin_center #(.LANES(LANES), .PH_W(PH_W), .MAX_DLY(MD), .LOCK_CNT(3)) u_rdwin_center (
      .clk(clk), .rst_n(rst_n), .start(start), .ecc_pass(ecc_pass),
      .full_rate(full_rate), .step_valid(step_valid), .step_phase(step_phase),
      .step_dly(step_dly), .step_last(step_last), .lane_match(lane_match),
      .lane_ovr(lane_ovr), .step_hold(step_hold), .all_done(all_done),
      .busy(busy), .res_valid(res_valid), .res_phase(res_phase),
      .res_dly(res_dly), .res_err(res_err), .min_phase(min_phase)
   );

   int n_chk = 0, n_err = 0;
   bit mon_on = 1'b0, finished = 1'b0;

   // Reference model state
   int m_st[NL], m_cnt[NL], m_sp[NL], m_sd[NL], m_ep[NL], m_ed[NL];
   int m_ecc = 0, m_fr = 0, m_lph = 0, m_ldl = 0, m_lok = 0;
   int win_lo[NL], win_hi[NL];

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit m_act(int k);
      return (m_ecc != 0) ? (k == LANES) : (k < LANES);
   endfunction

   function automatic int m_done();
      int c = 0;
      for (int k = 0; k < NL; k++) if (m_act(k) && m_st[k] == 2) c++;
      return (c == ((m_ecc != 0) ? 1 : LANES)) ? 1 : 0;
   endfunction

   // R4: closure count compared on every clock
   always @(negedge clk) if (mon_on) chk("R4 all_done", int'(all_done), m_done());

   task automatic begin_pass(bit ecc, bit fr);
      @(negedge clk);
      start = 1'b1; ecc_pass = ecc; full_rate = fr;
      @(posedge clk); #1;
      start = 1'b0;
      for (int k = 0; k < NL; k++) begin m_st[k] = 0; m_cnt[k] = 0; end
      m_ecc = ecc; m_fr = fr; m_lok = 0;
      chk("R9 start clears res_valid", int'(res_valid), 0);
   endtask

   task automatic step(int ph, int dl, logic [NL-1:0] hit, logic [NL-1:0] ovr, bit last);
      bit hold_exp = 1'b0;
      int same;
      @(negedge clk);
      step_valid = 1'b1; step_phase = PH_W'(ph); step_dly = DL_W'(dl);
      lane_match = hit; lane_ovr = ovr; step_last = last;
      #1;
      for (int k = 0; k < NL; k++) if (m_act(k) && ovr[k]) hold_exp = 1'b1;
      chk("R3 step_hold", int'(step_hold), int'(hold_exp));
      @(posedge clk); #1;
      same = (m_lok != 0 && ph == m_lph && dl == m_ldl) ? 1 : 0;
      m_lph = ph; m_ldl = dl; m_lok = 1;
      for (int k = 0; k < NL; k++) begin
         if (m_act(k) && !ovr[k]) begin
            if (m_st[k] == 0) begin
               if (hit[k]) begin
                  int c = ((same != 0) ? m_cnt[k] : 0) + 1;
                  if (c == 3) begin m_st[k] = 1; m_cnt[k] = 0; m_sp[k] = ph; m_sd[k] = dl; end
                  else m_cnt[k] = c;
               end else m_cnt[k] = 0;
            end else if (m_st[k] == 1) begin
               if (!hit[k] || last) begin m_st[k] = 2; m_ep[k] = ph; m_ed[k] = dl; end
            end
         end
      end
   endtask

   task automatic idle();
      @(negedge clk);
      step_valid = 1'b0; step_last = 1'b0; lane_match = '0; lane_ovr = '0;
   endtask

   function automatic int fold(int ph);
      return (m_fr != 0 && ph > 1) ? ph - 2 : ph;
   endfunction

   task automatic sweep(bit fr);
      for (int pi = 0; pi < 4; pi++)
         for (int dl = 0; dl < MD; dl++)
            for (int rep = 0; rep < 3; rep++) begin
               logic [NL-1:0] h, o;
               int p = pi * MD + dl;
               int ph = (fr && pi > 1) ? pi + 2 : pi;
               for (int k = 0; k < NL; k++) h[k] = (p >= win_lo[k] && p <= win_hi[k]);
               o = '0;
               if (!fr) begin
                  if (p == 25 && rep == 1) h[2] = 1'b0;
                  if ((p == 10 || p == 15) && rep == 0) o[1] = 1'b1;
                  if (p == 5 && rep == 0) o[4] = 1'b1;
               end
               step(ph, dl, h, o, (pi == 3 && dl == MD - 1));
            end
      idle();
   endtask

   task automatic check_results();
      int mn = 10;
      bit saw_busy = 1'b0;
      int waited = 0;
      while (!res_valid && waited < 1000) begin
         @(negedge clk);
         if (busy) saw_busy = 1'b1;
         waited++;
      end
      chk("R9 res_valid raised", int'(res_valid), 1);
      chk("R9 busy seen before results", int'(saw_busy), 1);
      chk("R9 busy low with results", int'(busy), 0);
      for (int k = 0; k < NL; k++) begin
         if (m_act(k)) begin
            int s = fold(m_sp[k]) * MD + m_sd[k];
            int e = fold(m_ep[k]) * MD + m_ed[k];
            int bad = (e < s) ? 1 : 0;
            int c = (bad != 0) ? s : s + (e - s) / 2;
            int q = c / MD;
            if (m_fr != 0 && q > 1) q = q + 2;
            if (q < mn) mn = q;
            chk("R5/R6 center phase", int'(res_phase[k*PH_W +: PH_W]), q);
            chk("R5 center delay", int'(res_dly[k*DL_W +: DL_W]), c % MD);
            chk("R8 error flag", int'(res_err[k]), bad);
         end
      end
      chk("R7 min_phase", int'(min_phase), mn);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < NL; k++) begin m_st[k] = 0; m_cnt[k] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R10: quiet outputs after reset
      chk("R10 all_done", int'(all_done), 0);
      chk("R10 busy", int'(busy), 0);
      chk("R10 res_valid", int'(res_valid), 0);
      chk("R10 step_hold", int'(step_hold), 0);
      mon_on = 1'b1;

      // Pass 1: half rate, data lanes; R1 lock restart, R2 end on last step, R3 overrun
      win_lo = '{60, 10, 25, 40, 0};
      win_hi = '{79, 30, 50, 44, 79};
      begin_pass(1'b0, 1'b0);
      sweep(1'b0);
      check_results();
      chk("R1 lane1 phase (lock at 11)", int'(res_phase[1*PH_W +: PH_W]), 1);
      chk("R1 lane1 delay (lock at 11)", int'(res_dly[1*DL_W +: DL_W]), 1);
      chk("R1 lane2 delay (lock at 26)", int'(res_dly[2*DL_W +: DL_W]), 18);
      chk("R2 lane0 phase (end on last)", int'(res_phase[0*PH_W +: PH_W]), 3);
      chk("R2 lane0 delay (end on last)", int'(res_dly[0*DL_W +: DL_W]), 9);
      chk("R7 pass1 minimum", int'(min_phase), 1);

      // Pass 2: full rate, phases 0,1,4,5
      win_lo = '{30, 0, 70, 60, 0};
      win_hi = '{55, 3, 79, 62, 79};
      begin_pass(1'b0, 1'b1);
      sweep(1'b1);
      check_results();
      chk("R6 lane0 folded phase", int'(res_phase[0*PH_W +: PH_W]), 4);
      chk("R6 lane0 folded delay", int'(res_dly[0*DL_W +: DL_W]), 3);
      chk("R6 lane2 folded phase", int'(res_phase[2*PH_W +: PH_W]), 5);
      chk("R7 pass2 minimum", int'(min_phase), 0);

      // Pass 3: check-bit lane only; data-lane overrun ignored; end before start
      begin_pass(1'b1, 1'b0);
      for (int r = 0; r < 3; r++) step(2, 5, 5'b11010, 5'b00001, 1'b0);
      idle();
      chk("R4 not done after lock", int'(all_done), 0);
      step(0, 3, 5'b01111, 5'b00010, 1'b0);
      idle();
      chk("R4 done with check lane only", int'(all_done), 1);
      check_results();
      chk("R8 error lane flag", int'(res_err[4]), 1);
      chk("R8 error lane phase", int'(res_phase[4*PH_W +: PH_W]), 2);
      chk("R8 error lane delay", int'(res_dly[4*DL_W +: DL_W]), 5);
      chk("R7 pass3 minimum", int'(min_phase), 2);
      repeat (3) @(negedge clk);
      chk("R9 results held", int'(res_valid), 1);

      mon_on = 1'b0;
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule